// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one 8-pin general-purpose I/O port. Software sees four writable configuration registers and one read-only pin-state register. The four writable registers hold direction, output data, pull direction and drive strength. Every pin is set up on its own, so a port may mix inputs and outputs in any pattern. The controller turns the register bits into per-pin pad controls: output enable, output value, pull enable, pull-up select and strong-drive select.

The output-data register has two roles. On an output pin it holds the level to drive. On an input pin it switches a weak resistive pull on or off. When the pull is on, its direction comes from the pull-direction register. Drive strength only matters while a pin is an output.

Pad inputs pass through a two-flop synchroniser and land in the pin-state register, whatever direction each pin has. A simple register bus writes either a whole byte or one selected bit. Reads are combinational and return either a whole byte or one selected bit.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the direction, output-data and drive-strength registers read 00h and the pull-direction register reads FFh. Every pin is therefore an input with no pull and no drive.
- R2: A pin with direction bit 0 and output-data bit 0 has pad_oe, pad_out, pad_pull_en and pad_pull_up all at 0.
- R3: A pin with direction bit 0 and output-data bit 1 has pad_pull_en at 1. Its pad_pull_up equals its pull-direction bit, where 1 selects pullup and 0 selects pulldown.
- R4: A pin with direction bit 1 has pad_oe at 1, pad_out equal to its output-data bit, and pad_pull_en and pad_pull_up at 0.
- R5: pad_drive_hi equals the drive-strength bit on an output pin (1 selects strong drive, 0 selects weak drive). It is 0 on an input pin, whatever the drive-strength bit holds.
- R6: A write with bus_bit=0 replaces all 8 bits of the selected register with bus_wdata at the clock edge that samples bus_wr.
- R7: A write with bus_bit=1 sets bit bus_idx of the selected register to bus_wdata[0] and leaves the other seven bits unchanged.
- R8: The pin-state register shows pad_in as it was two clock edges earlier, for input and output pins alike.
- R9: Writes with bus_sel 4 to 7 change no register. The pin-state register keeps following pad_in.
- R10: rd_data shows the register chosen by bus_sel in the same cycle: 0 direction, 1 output data, 2 pull direction, 3 drive strength, 4 pin state, 5 to 7 read 00h. rd_bit equals rd_data[bus_idx].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| bus_sel | input | 3 | Register select |
| bus_idx | input | 3 | Bit index for bit access |
| bus_wdata | input | 8 | Write data (bit 0 is used for bit writes) |
| rd_data | output | 8 | Selected register value |
| rd_bit | output | 1 | Selected bit of rd_data |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pull_en | output | 8 | Per-pin resistive pull enable |
| pad_pull_up | output | 8 | Per-pin pull direction, 1 = up |
| pad_drive_hi | output | 8 | Per-pin strong-drive select |

## Verification
A software write to the pin-state register can arrive in the same cycle as a change on pad_in, and the write must not disturb the synchroniser. The bench changes pad_in on the same edge at which it writes the complement of the new pad value to select 4. It then reads the pin-state register after one edge, where it expects the old level, and after two edges, where it expects the new level. Random traffic also mixes byte and bit writes with reads of every select, and each result is compared with values computed by bench functions.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_OUT  = 3'd1,
        SEL_PULL = 3'd2,
        SEL_DRV  = 3'd3,
        SEL_PIN  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             bit_mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [IW-1:0]    idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     dir,
    output logic [W-1:0]     outd,
    output logic [W-1:0]     pull,
    output logic [W-1:0]     drv
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] outd;
        logic [W-1:0] pull;
        logic [W-1:0] drv;
    } regs_t;

    localparam regs_t RST_VAL = '{dir: '0, outd: '0, pull: '1, drv: '0};

    regs_t regs_d, regs_q;

    // Byte mode takes all of wdata; bit mode replaces one position only.
    function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                           input logic         bm,
                                           input logic [IW-1:0] i,
                                           input logic [W-1:0] d);
        logic [W-1:0] r;
        if (bm) begin
            r    = old;
            r[i] = d[0];
        end else begin
            r = d;
        end
        return r;
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (sel)
                SEL_DIR:  regs_d.dir  = merge(regs_q.dir,  bit_mode, idx, wdata);
                SEL_OUT:  regs_d.outd = merge(regs_q.outd, bit_mode, idx, wdata);
                SEL_PULL: regs_d.pull = merge(regs_q.pull, bit_mode, idx, wdata);
                SEL_DRV:  regs_d.drv  = merge(regs_q.drv,  bit_mode, idx, wdata);
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    assign dir  = regs_q.dir;
    assign outd = regs_q.outd;
    assign pull = regs_q.pull;
    assign drv  = regs_q.drv;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = async_in;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.stable;

endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] outd,
    input  logic [W-1:0] pull,
    input  logic [W-1:0] drv,
    output logic [W-1:0] oe,
    output logic [W-1:0] dout,
    output logic [W-1:0] pull_en,
    output logic [W-1:0] pull_up,
    output logic [W-1:0] drive_hi
);

    for (genvar p = 0; p < W; p++) begin : g_pin
        // Output pin: drive data, no pull. Input pin: data bit gates the pull.
        always_comb begin
            if (dir[p]) begin
                oe[p]       = 1'b1;
                dout[p]     = outd[p];
                pull_en[p]  = 1'b0;
                pull_up[p]  = 1'b0;
                drive_hi[p] = drv[p];
            end else begin
                oe[p]       = 1'b0;
                dout[p]     = 1'b0;
                pull_en[p]  = outd[p];
                pull_up[p]  = outd[p] & pull[p];
                drive_hi[p] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_bit,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [IW-1:0]    bus_idx,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     rd_data,
    output logic             rd_bit,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pull_en,
    output logic [W-1:0]     pad_pull_up,
    output logic [W-1:0]     pad_drive_hi
);

    logic [W-1:0] dir_w, outd_w, pull_w, drv_w, pin_w;

    gpio_regfile #(.W(W), .IW(IW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .bit_mode (bus_bit),
        .sel      (bus_sel),
        .idx      (bus_idx),
        .wdata    (bus_wdata),
        .dir      (dir_w),
        .outd     (outd_w),
        .pull     (pull_w),
        .drv      (drv_w)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_w)
    );

    gpio_pin_decode #(.W(W)) u_dec (
        .dir      (dir_w),
        .outd     (outd_w),
        .pull     (pull_w),
        .drv      (drv_w),
        .oe       (pad_oe),
        .dout     (pad_out),
        .pull_en  (pad_pull_en),
        .pull_up  (pad_pull_up),
        .drive_hi (pad_drive_hi)
    );

    always_comb begin
        case (bus_sel)
            SEL_DIR:  rd_data = dir_w;
            SEL_OUT:  rd_data = outd_w;
            SEL_PULL: rd_data = pull_w;
            SEL_DRV:  rd_data = drv_w;
            SEL_PIN:  rd_data = pin_w;
            default:  rd_data = '0;
        endcase
        rd_bit = rd_data[bus_idx];
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_bit,
    input logic [SEL_W-1:0] bus_sel,
    input logic [IW-1:0]    bus_idx,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     pad_in,
    input logic [W-1:0]     pin,
    input logic [W-1:0]     dir,
    input logic [W-1:0]     outd,
    input logic [W-1:0]     pull,
    input logic [W-1:0]     drv,
    input logic [W-1:0]     pad_oe,
    input logic [W-1:0]     pad_pull_en,
    input logic [W-1:0]     pad_drive_hi
);

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir == '0 && outd == '0 && drv == '0 && pull == '1));

    // R4
    no_pull_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);

    // R5
    no_drive_on_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drive_hi & ~pad_oe) == '0);

    // R6
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_bit && bus_sel == SEL_DIR) |=> dir == $past(bus_wdata));

    // R7
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bit && bus_sel == SEL_OUT) |=>
        (outd[$past(bus_idx)] == $past(bus_wdata[0]) &&
         ((outd ^ $past(outd)) & ~(W'(1) << $past(bus_idx))) == '0));

    // R9
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel >= SEL_PIN) |=>
        ($stable(dir) && $stable(outd) && $stable(pull) && $stable(drv)));

    // R8
    pin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> pin == $past(pad_in, 2));

endmodule

bind gpio_port_ctl gpio_port_chk #(.W(W), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_bit      (bus_bit),
    .bus_sel      (bus_sel),
    .bus_idx      (bus_idx),
    .bus_wdata    (bus_wdata),
    .pad_in       (pad_in),
    .pin          (pin_w),
    .dir          (dir_w),
    .outd         (outd_w),
    .pull         (pull_w),
    .drv          (drv_w),
    .pad_oe       (pad_oe),
    .pad_pull_en  (pad_pull_en),
    .pad_drive_hi (pad_drive_hi)
);

// File: tb/sim_gpio_port_ctl.sv
module sim_gpio_port_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_bit = 1'b0;
    logic [2:0] bus_sel = '0;
    logic [2:0] bus_idx = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] rd_data, pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_drive_hi;
    logic       rd_bit;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] m_dir, m_out, m_pull, m_drv, m_pin;

    always #10 clk = ~clk;

    gpio_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bit(bus_bit),
        .bus_sel(bus_sel), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_bit(rd_bit), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .pad_drive_hi(pad_drive_hi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] upd(input logic [7:0] old, input logic b,
                                       input logic [2:0] i, input logic [7:0] d);
        logic [7:0] r = old;
        if (b) r[i] = d[0];
        else   r = d;
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd0: return m_dir;
            3'd1: return m_out;
            3'd2: return m_pull;
            3'd3: return m_drv;
            3'd4: return m_pin;
            default: return 8'h00;
        endcase
    endfunction

    task automatic write(input logic [2:0] s, input logic b, input logic [2:0] i,
                         input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_bit = b; bus_idx = i; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (s)
            3'd0: m_dir  = upd(m_dir,  b, i, d);
            3'd1: m_out  = upd(m_out,  b, i, d);
            3'd2: m_pull = upd(m_pull, b, i, d);
            3'd3: m_drv  = upd(m_drv,  b, i, d);
            default: ;
        endcase
    endtask

    task automatic check_pads();
        chk("R4 pad_oe", pad_oe, m_dir);
        chk("R4 pad_out", pad_out, m_dir & m_out);
        chk("R2 R3 pad_pull_en", pad_pull_en, ~m_dir & m_out);
        chk("R3 pad_pull_up", pad_pull_up, ~m_dir & m_out & m_pull);
        chk("R5 pad_drive_hi", pad_drive_hi, m_dir & m_drv);
    endtask

    task automatic check_read(input logic [2:0] s, input logic [2:0] i);
        logic [7:0] e;
        bus_sel = s; bus_idx = i;
        #1;
        e = exp_rd(s);
        chk("R10 rd_data", rd_data, e);
        chk("R10 rd_bit", {7'd0, rd_bit}, {7'd0, e[i]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357));
        m_dir = 8'h00; m_out = 8'h00; m_pull = 8'hFF; m_drv = 8'h00; m_pin = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            bus_sel = 3'(s); #1;
            chk("R1 reset reg", rd_data, exp_rd(3'(s)));
        end
        chk("R1 reset oe", pad_oe, 8'h00);
        chk("R1 reset pull_en", pad_pull_en, 8'h00);
        check_pads();

        // R3 directed: pulls on all inputs, mixed direction
        write(3'd1, 1'b0, 3'd0, 8'hFF);
        check_pads();
        write(3'd2, 1'b0, 3'd0, 8'h0F);
        check_pads();
        // R5 drive bits on inputs have no effect
        write(3'd3, 1'b0, 3'd0, 8'hFF);
        chk("R5 drive ignored on inputs", pad_drive_hi, 8'h00);
        // R4 outputs
        write(3'd0, 1'b0, 3'd0, 8'hA5);
        check_pads();
        // R7 single bit write
        write(3'd0, 1'b1, 3'd6, 8'h01);
        check_read(3'd0, 3'd6);
        chk("R7 bit write", rd_data, 8'hE5);
        // R9 write to unused select
        write(3'd6, 1'b0, 3'd0, 8'h00);
        for (int s = 0; s < 8; s++) check_read(3'(s), 3'(s));
        chk("R9 unused write", pad_oe, 8'hE5);

        // R8 R9 concurrent: pad change and write to the pin register on one edge
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        m_pin = 8'h3C;
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 3'd4; bus_bit = 1'b0; bus_wdata = 8'h3A; pad_in = 8'hC5;
        @(negedge clk);
        bus_wr = 1'b0; #1;
        chk("R8 one edge old", rd_data, 8'h3C);
        @(negedge clk); #1;
        chk("R8 R9 two edges new", rd_data, 8'hC5);
        m_pin = 8'hC5;

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [2:0] s;
            s = 3'($urandom % 8);
            if (n % 50 == 49) begin
                pad_in = 8'($urandom);
                repeat (2) @(negedge clk);
                m_pin = pad_in;
                check_read(3'd4, 3'($urandom % 8));
            end
            write(s, 1'($urandom % 2), 3'($urandom % 8), 8'($urandom));
            check_pads();
            check_read(3'($urandom % 8), 3'($urandom % 8));
        end

        // R6 byte write final
        write(3'd2, 1'b0, 3'd0, 8'h5A);
        check_read(3'd2, 3'd1);
        chk("R6 byte write", rd_data, 8'h5A);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule